// File: doc/BRIEF.md
# Character Text Overlay Mixer

This block lays a grid of text, 40 character cells across and 25 down, over a Y/Cb/Cr 4:4:4 pixel stream. Every pixel arrives with a valid flag and two timing flags: one marks the first pixel of a field and one marks the first pixel of each later line. A position tracker turns these flags into a column and a line count within the field. Each cell is 8 pixels wide and 8 lines high. The cell's character code is read from a 1024-byte text store, and then one glyph row is read from a 1024-byte glyph store. The mixer then picks the output pixel from the live video, the text colour or the box colour.

The line count restarts at every field-start flag. Both fields of an interlaced frame therefore show the same text. A code of zero hides the cell. A code from 1 to 127 draws the glyph over the live picture. A code with its top bit set draws the same glyph, chosen by the low seven bits, inside a solid box in the background colour. A host write port loads both stores and the six colour bytes. The output is the mixed stream, delayed by a fixed three cycles. The timing flags are delayed by the same three cycles.

Top module: `ovl_text_mixer`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid, out_sof, out_sol and all output pixel bytes are 0.
- R2: Every input pixel with in_valid=1 appears on the outputs exactly 3 clock cycles later, with out_sof and out_sol equal to its input flags. out_valid is the input valid delayed by 3 cycles, and idle cycles stay idle.
- R3: A pixel inside the text area whose cell code is 0 leaves the block with its Y, Cb and Cr unchanged.
- R4: For codes 1 to 127, a glyph bit of 1 outputs the text colour and a glyph bit of 0 outputs the live pixel.
- R5: For codes 128 to 255, a glyph bit of 1 outputs the text colour and a glyph bit of 0 outputs the background colour.
- R6: The glyph byte for a pixel is at glyph address code[6:0]*8 + (line mod 8). Bit 7 of that byte is the leftmost pixel of the cell (pixel column mod 8 = 0) and bit 0 is the rightmost.
- R7: The cell code for a pixel is at text address (line/8)*40 + (column/8).
- R8: Pixels at column 320 or above, or at line 200 or above, pass through unchanged.
- R9: A valid pixel with in_sof=1 is column 0 of line 0. A valid pixel with in_sol=1 (and in_sof=0) is column 0 of the next line. Any other valid pixel is one column to the right of the previous one. This means both fields of a frame show the same overlay.
- R10: The colour bytes are written with wr_tgt=2 at these addresses: 0 text Y, 1 text Cr, 2 text Cb, 3 box Y, 4 box Cr, 5 box Cb. After reset, text is Y=235, Cr=128, Cb=128 and the box is Y=16, Cr=128, Cb=128.
- R11: wr_tgt=0 writes the text store and wr_tgt=1 writes the glyph store. A write with wr_tgt=3, or a colour write at an address above 5, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | Pixel is the first of a field |
| in_sol | input | 1 | Pixel is the first of a new line |
| in_y | input | 8 | Input luma |
| in_cb | input | 8 | Input blue chroma |
| in_cr | input | 8 | Input red chroma |
| wr_en | input | 1 | Host write strobe |
| wr_tgt | input | 2 | Write target: 0 text, 1 glyph, 2 colour, 3 none |
| wr_addr | input | 10 | Host write address |
| wr_data | input | 8 | Host write byte |
| out_valid | output | 1 | Output pixel present |
| out_sof | output | 1 | Delayed field-start flag |
| out_sol | output | 1 | Delayed line-start flag |
| out_y | output | 8 | Mixed luma |
| out_cb | output | 8 | Mixed blue chroma |
| out_cr | output | 8 | Mixed red chroma |

## Verification
The stream has random pixel data and random idle gaps. It covers lines that hold hidden cells, plain-text cells and boxed cells, in a first and a second cell row. It also covers long lines that cross column 320 and the last cell row, and lines past line 200. A random live pixel tells pass-through apart from a colour substitution. Boxed and plain cells share one glyph, so the bits set to 0 tell the box colour apart from live video. The first field uses the reset colours and the second uses colours written by the host, after ignored writes. This tells a correct restart of the line count at the field flag, and the write decoding, apart from a stale or misdirected store.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } ycc_t;

    typedef enum logic [1:0] {
        TGT_TEXT   = 2'd0,
        TGT_GLYPH  = 2'd1,
        TGT_COLOUR = 2'd2,
        TGT_NONE   = 2'd3
    } wr_tgt_e;

    // pipeline control carried beside the pixel
    typedef struct packed {
        logic valid;
        logic sof;
        logic sol;
        logic area;
        ycc_t pix;
    } stage_t;

    localparam int GLYPH_W       = 8;
    localparam int CODE_IDX_W    = 7;
    localparam ycc_t FG_RESET    = '{y: 8'd235, cb: 8'd128, cr: 8'd128};
    localparam ycc_t BG_RESET    = '{y: 8'd16,  cb: 8'd128, cr: 8'd128};

    function automatic ycc_t blend(input ycc_t vid, input logic area,
                                   input logic [7:0] code, input logic gbit,
                                   input ycc_t fg, input ycc_t bg);
        if (!area || code == 8'd0) return vid;
        if (gbit)                  return fg;
        if (code[7])               return bg;
        return vid;
    endfunction

endpackage

// File: rtl/ovl_pos_track.sv
module ovl_pos_track #(
    parameter int X_W = 11,
    parameter int Y_W = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid,
    input  logic           sof,
    input  logic           sol,
    output logic [X_W-1:0] cur_x,
    output logic [Y_W-1:0] cur_y
);
    logic [X_W-1:0] next_x_q;
    logic [Y_W-1:0] line_q;

    always_comb begin
        cur_x = (sof || sol) ? '0 : next_x_q;
        if (sof)
            cur_y = '0;
        else if (sol)
            cur_y = (line_q == '1) ? line_q : line_q + 1'b1;
        else
            cur_y = line_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_x_q <= '0;
            line_q   <= '0;
        end else if (valid) begin
            next_x_q <= (cur_x == '1) ? cur_x : cur_x + 1'b1;
            line_q   <= cur_y;
        end
    end
endmodule

// File: rtl/ovl_ram.sv
module ovl_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/ovl_colour_regs.sv
module ovl_colour_regs
    import ovl_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    data,
    output ycc_t          fg,
    output ycc_t          bg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fg <= FG_RESET;
            bg <= BG_RESET;
        end else if (we) begin
            case (addr)
                AW'(0): fg.y  <= data;
                AW'(1): fg.cr <= data;
                AW'(2): fg.cb <= data;
                AW'(3): bg.y  <= data;
                AW'(4): bg.cr <= data;
                AW'(5): bg.cb <= data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ovl_text_mixer.sv
module ovl_text_mixer
    import ovl_pkg::*;
#(
    parameter int COLS      = 40,
    parameter int ROWS      = 25,
    parameter int CELL_H_LG = 3,
    parameter int TEXT_AW   = 10,
    parameter int HOST_AW   = 10,
    parameter int X_W       = 11,
    parameter int Y_W       = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_sol,
    input  logic [7:0]         in_y,
    input  logic [7:0]         in_cb,
    input  logic [7:0]         in_cr,
    input  logic               wr_en,
    input  logic [1:0]         wr_tgt,
    input  logic [HOST_AW-1:0] wr_addr,
    input  logic [7:0]         wr_data,
    output logic               out_valid,
    output logic               out_sof,
    output logic               out_sol,
    output logic [7:0]         out_y,
    output logic [7:0]         out_cb,
    output logic [7:0]         out_cr
);
    localparam int CELL_W_LG = $clog2(GLYPH_W);
    localparam int CELL_H    = 1 << CELL_H_LG;
    localparam int AREA_W    = COLS * GLYPH_W;
    localparam int AREA_H    = ROWS * CELL_H;
    localparam int GLYPH_AW  = CODE_IDX_W + CELL_H_LG;
    localparam int IDX_W     = X_W + Y_W;

    // host write decode
    logic wr_text, wr_glyph, wr_col;
    always_comb begin
        wr_text  = wr_en && (wr_tgt_e'(wr_tgt) == TGT_TEXT);
        wr_glyph = wr_en && (wr_tgt_e'(wr_tgt) == TGT_GLYPH);
        wr_col   = wr_en && (wr_tgt_e'(wr_tgt) == TGT_COLOUR);
    end

    ycc_t fg, bg;
    ovl_colour_regs #(.AW(HOST_AW)) u_colour (
        .clk (clk), .rst (rst), .we (wr_col), .addr (wr_addr), .data (wr_data),
        .fg  (fg),  .bg  (bg)
    );

    // stage 0: position and text lookup address
    logic [X_W-1:0] cur_x;
    logic [Y_W-1:0] cur_y;
    ovl_pos_track #(.X_W(X_W), .Y_W(Y_W)) u_pos (
        .clk (clk), .rst (rst), .valid (in_valid), .sof (in_sof), .sol (in_sol),
        .cur_x (cur_x), .cur_y (cur_y)
    );

    logic               area0;
    logic [IDX_W-1:0]   cell_idx;
    logic [TEXT_AW-1:0] text_raddr;
    always_comb begin
        area0      = (int'(cur_x) < AREA_W) && (int'(cur_y) < AREA_H);
        cell_idx   = IDX_W'(cur_y >> CELL_H_LG) * IDX_W'(COLS)
                   + IDX_W'(cur_x >> CELL_W_LG);
        text_raddr = cell_idx[TEXT_AW-1:0];
    end

    logic [7:0] code_s1;
    ovl_ram #(.AW(TEXT_AW), .DW(8)) u_text (
        .clk (clk), .we (wr_text), .waddr (wr_addr[TEXT_AW-1:0]), .wdata (wr_data),
        .raddr (text_raddr), .rdata (code_s1)
    );

    // stage 1: code known, glyph lookup
    stage_t               s1_q;
    logic [CELL_H_LG-1:0] gline_s1;
    logic [CELL_W_LG-1:0] gcol_s1;
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q     <= '0;
            gline_s1 <= '0;
            gcol_s1  <= '0;
        end else begin
            s1_q     <= '{valid: in_valid, sof: in_valid && in_sof,
                          sol: in_valid && in_sol, area: area0,
                          pix: '{y: in_y, cb: in_cb, cr: in_cr}};
            gline_s1 <= cur_y[CELL_H_LG-1:0];
            gcol_s1  <= cur_x[CELL_W_LG-1:0];
        end
    end

    logic [GLYPH_AW-1:0] glyph_raddr;
    logic [GLYPH_W-1:0]  glyph_byte;
    assign glyph_raddr = {code_s1[CODE_IDX_W-1:0], gline_s1};

    ovl_ram #(.AW(GLYPH_AW), .DW(GLYPH_W)) u_glyph (
        .clk (clk), .we (wr_glyph), .waddr (wr_addr[GLYPH_AW-1:0]), .wdata (wr_data),
        .raddr (glyph_raddr), .rdata (glyph_byte)
    );

    // stage 2: glyph row known, select pixel
    stage_t               s2_q;
    logic [7:0]           code_s2;
    logic [CELL_W_LG-1:0] gcol_s2;
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q    <= '0;
            code_s2 <= '0;
            gcol_s2 <= '0;
        end else begin
            s2_q    <= s1_q;
            code_s2 <= code_s1;
            gcol_s2 <= gcol_s1;
        end
    end

    logic s2_bit;
    assign s2_bit = glyph_byte[~gcol_s2];

    // stage 3: registered output
    ycc_t out_pix;
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_sol   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s2_q.valid;
            out_sof   <= s2_q.sof;
            out_sol   <= s2_q.sol;
            out_pix   <= blend(s2_q.pix, s2_q.area, code_s2, s2_bit, fg, bg);
        end
    end

    assign out_y  = out_pix.y;
    assign out_cb = out_pix.cb;
    assign out_cr = out_pix.cr;
endmodule

// File: rtl/ovl_text_mixer_chk.sv
module ovl_text_mixer_chk
    import ovl_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_sof,
    input logic       in_sol,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_sol,
    input ycc_t       out_pix,
    input logic       s2_valid,
    input logic       s2_area,
    input logic [7:0] s2_code,
    input logic       s2_bit,
    input ycc_t       s2_pix,
    input ycc_t       fg,
    input ycc_t       bg
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)            age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_sof && !out_sol && out_pix == '0));

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R2
    flag_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid) |->
            (out_sof == $past(in_sof, 3) && out_sol == $past(in_sol, 3)));

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (s2_valid && (!s2_area || s2_code == 8'd0)) |=> (out_pix == $past(s2_pix)));

    // R4
    plain_text_chk: assert property (@(posedge clk) disable iff (rst)
        (s2_valid && s2_area && s2_code != 8'd0 && !s2_code[7]) |=>
            (out_pix == ($past(s2_bit) ? $past(fg) : $past(s2_pix))));

    // R5
    boxed_text_chk: assert property (@(posedge clk) disable iff (rst)
        (s2_valid && s2_area && s2_code[7]) |=>
            (out_pix == ($past(s2_bit) ? $past(fg) : $past(bg))));
endmodule

bind ovl_text_mixer ovl_text_mixer_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_sol    (in_sol),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_sol   (out_sol),
    .out_pix   (out_pix),
    .s2_valid  (s2_q.valid),
    .s2_area   (s2_q.area),
    .s2_code   (code_s2),
    .s2_bit    (s2_bit),
    .s2_pix    (s2_q.pix),
    .fg        (fg),
    .bg        (bg)
);

// File: tb/ovl_text_mixer_tb_top.sv
`timescale 1ns/1ps
module ovl_text_mixer_tb_top;
    import ovl_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 0, in_sof = 0, in_sol = 0;
    logic [7:0] in_y = 0, in_cb = 0, in_cr = 0;
    logic       wr_en = 0;
    logic [1:0] wr_tgt = 0;
    logic [9:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic       out_valid, out_sof, out_sol;
    logic [7:0] out_y, out_cb, out_cr;

    always #10 clk = ~clk;

    ovl_text_mixer dut_i (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_sof (in_sof), .in_sol (in_sol),
        .in_y (in_y), .in_cb (in_cb), .in_cr (in_cr), .wr_en (wr_en), .wr_tgt (wr_tgt),
        .wr_addr (wr_addr), .wr_data (wr_data), .out_valid (out_valid), .out_sof (out_sof),
        .out_sol (out_sol), .out_y (out_y), .out_cb (out_cb), .out_cr (out_cr)
    );

    typedef struct {
        ycc_t  pix;
        logic  sof;
        logic  sol;
        int    stamp;
        string tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    int         cyc    = 0;
    logic [7:0] text_m  [1024];
    logic [7:0] glyph_m [1024];
    ycc_t       fg_m, bg_m;
    int         bx = 0, by = 0;
    string      sfx = "";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: compare every produced pixel with the scoreboard head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R2", "unexpected output pixel", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({out_y, out_cb, out_cr} == e.pix, e.tag, "pixel",
                    {out_y, out_cb, out_cr}, e.pix);
                chk(out_sof == e.sof && out_sol == e.sol, "R2 R9", "flags",
                    {out_sof, out_sol}, {e.sof, e.sol});
                chk(cyc == e.stamp + 3, "R2", "latency", cyc - e.stamp, 3);
            end
        end
    end

    function automatic logic [7:0] glyph_pat(input int c, input int r);
        return 8'((c * 29) ^ (r * 71) ^ 8'hC3);
    endfunction

    task automatic host_write(input logic [1:0] tgt, input int addr, input logic [7:0] d);
        wr_en = 1; wr_tgt = tgt; wr_addr = 10'(addr); wr_data = d;
        if (tgt == 2'd0) text_m[addr] = d;
        else if (tgt == 2'd1) glyph_m[addr] = d;
        else if (tgt == 2'd2) begin
            case (addr)
                0: fg_m.y  = d;
                1: fg_m.cr = d;
                2: fg_m.cb = d;
                3: bg_m.y  = d;
                4: bg_m.cr = d;
                5: bg_m.cb = d;
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        in_valid = 0; in_sof = 0; in_sol = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_px(input logic sof, input logic sol);
        exp_t       e;
        ycc_t       vid;
        logic [7:0] code, g;
        logic       gbit, area;
        vid = '{y: 8'($urandom), cb: 8'($urandom), cr: 8'($urandom)};
        in_valid = 1; in_sof = sof; in_sol = sol;
        in_y = vid.y; in_cb = vid.cb; in_cr = vid.cr;
        if (sof) begin bx = 0; by = 0; end
        else if (sol) begin bx = 0; by = by + 1; end
        area = (bx < 320) && (by < 200);
        code = area ? text_m[(by / 8) * 40 + bx / 8] : 8'd0;
        g    = glyph_m[{code[6:0], 3'(by % 8)}];
        gbit = g[7 - (bx % 8)];
        e.sof = sof; e.sol = sol && !sof; e.stamp = cyc;
        if (!area)            begin e.pix = vid; e.tag = {"R8", sfx}; end
        else if (code == 0)   begin e.pix = vid; e.tag = {"R3", sfx}; end
        else if (!code[7])    begin e.pix = gbit ? fg_m : vid;  e.tag = {"R4 R6 R7", sfx}; end
        else                  begin e.pix = gbit ? fg_m : bg_m; e.tag = {"R5 R6 R7", sfx}; end
        sb.push_back(e);
        bx = bx + 1;
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_sol = 0;
    endtask

    task automatic drive_field();
        for (int l = 0; l < 202; l++) begin
            int w;
            w = (l < 16) ? 24 : (l < 192) ? 2 : 330;
            for (int i = 0; i < w; i++) begin
                if ($urandom_range(0, 5) == 0) idle(1);
                send_px(l == 0 && i == 0, l != 0 && i == 0);
            end
        end
        idle(8);
    endtask

    initial begin
        fg_m = '{y: 8'd235, cb: 8'd128, cr: 8'd128};
        bg_m = '{y: 8'd16,  cb: 8'd128, cr: 8'd128};
        for (int i = 0; i < 1024; i++) glyph_m[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1: outputs quiet in reset
        chk(!out_valid && !out_sof && !out_sol && {out_y, out_cb, out_cr} == 24'd0,
            "R1", "outputs during reset", {out_valid, out_y, out_cb, out_cr}, 0);
        rst = 0;
        @(negedge clk);
        chk(!out_valid && {out_y, out_cb, out_cr} == 24'd0, "R1", "outputs after reset",
            {out_valid, out_y, out_cb, out_cr}, 0);

        // R11: load stores through their targets
        for (int i = 0; i < 1000; i++) host_write(2'd0, i, 8'd0);
        for (int i = 0; i < 8; i++) begin
            host_write(2'd1, 1 * 8 + i, glyph_pat(1, i));
            host_write(2'd1, 2 * 8 + i, glyph_pat(2, i));
            host_write(2'd1, 5 * 8 + i, glyph_pat(5, i));
        end
        host_write(2'd0, 0,       8'd1);    // row 0 col 0 plain
        host_write(2'd0, 1,       8'h81);   // row 0 col 1 boxed, glyph 1
        host_write(2'd0, 40,      8'h82);   // row 1 col 0 boxed, glyph 2
        host_write(2'd0, 42,      8'd5);    // row 1 col 2 plain
        host_write(2'd0, 24 * 40, 8'h85);   // row 24 col 0 boxed
        host_write(2'd0, 999,     8'd2);    // row 24 col 39 plain
        idle(4);

        // field 1 with reset colours (R10)
        sfx = " R10";
        drive_field();

        // new colours, plus writes that must be ignored (R11)
        host_write(2'd2, 0, 8'd81);
        host_write(2'd2, 1, 8'd90);
        host_write(2'd2, 2, 8'd240);
        host_write(2'd2, 3, 8'd41);
        host_write(2'd2, 4, 8'd230);
        host_write(2'd2, 5, 8'd110);
        host_write(2'd2, 7, 8'hEE);
        host_write(2'd3, 0, 8'hFF);
        host_write(2'd3, 9, 8'hFF);
        idle(4);

        // field 2 repeats the overlay after a field restart (R9)
        sfx = " R9 R10 R11";
        drive_field();
        idle(6);
        chk(sb.size() == 0, "R2", "pixels left unreturned", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule